// File: doc/BRIEF.md
# Serial Slot Word Capture

This block takes one serial word per frame slot from one of two serial input ports and hands it to a processing core in the system clock domain. Both ports share a single chip-enable window. A direction select, held steady while the window is open, chooses which port is active. The transmit port carries an 8-bit companded sample, clocked on its own sample bit clock. The receive port carries a coded word of 2 to 5 bits, clocked on a separate code bit clock. Bits are taken on the falling edge of their bit clock, and only while the window is open. When chip enable falls, the block freezes the trailing bits of the selected port. It also samples the per-slot control fields at that edge: rate code, coding-law bit, channel-enable bit and init bit.

The falling edge of chip enable is brought into the system clock through a two-flop synchronizer. Once the synchronized fall is seen, the frozen word and its fields move into an output stage. That stage drives a valid/ready stream. `out_valid` rises with a new word and stays high until a cycle in which `out_ready` is high. Until then, the word and all its fields hold still. When `out_ready` is held high, each slot gives a one-cycle valid pulse. The output stage stores one word and does not queue. A slot whose fall is detected while an earlier word is still waiting, and not taken in that same cycle, is discarded. A fall detected in the very cycle the waiting word is taken loads the new word, and valid stays high.

Top module: `slot_capture`

## Requirements
- R1: A transmit-port bit shifts in on a falling edge of `pcm_sclk` only while `ce` is 1 and `dir_sel` is 1. Edges outside that condition leave the transmit register unchanged.
- R2: A receive-port bit shifts in on a falling edge of `code_sclk` only while `ce` is 1 and `dir_sel` is 0. Edges outside that condition leave the receive register unchanged.
- R3: For a transmit slot (`out_dir`=1), `out_word` is the last 8 transmit bits before `ce` fell. The earliest of those bits is at bit 7 and the final bit is at bit 0, so extra clocks push older bits out.
- R4: For a receive slot with rate code 11 (5-bit code), `out_word[4:0]` holds the last 5 received bits, the final bit at bit 0, and `out_word[7:5]` is 0.
- R5: For a receive slot with rate code 00 (4-bit), 01 (3-bit) or 10 (2-bit), `out_word[3:0]` holds the last 4 received bits and `out_word[7:4]` is 0. A 3-bit code sits in bits 3..1 and a 2-bit code sits in bits 3..2.
- R6: `out_dir`, `out_rate`, `out_law`, `out_en` and `out_init` carry the values that `dir_sel`, `rate_sel`, `law_sel`, `chan_en` and `chan_init` had when `ce` fell. They are presented together with the word.
- R7: If `ce` falls between two rising `clk` edges, `out_valid` is first seen high after the third rising edge that follows. It is still low after the second.
- R8: While `out_valid` is 1 and `out_ready` is 0, `out_valid` stays 1 and the word and all fields stay unchanged.
- R9: A slot whose fall is detected while a word is waiting, with `out_ready` low in that cycle, is discarded. The waiting word is then delivered unchanged.
- R10: A fall detected in the same cycle that a waiting word is taken loads the new word, and `out_valid` stays 1.
- R11: `rst_n` low clears both shift registers and the output stage at once, without waiting for a clock: `out_valid`=0 and `out_word`=0.
- R12: After a cycle with `out_valid` and `out_ready` both 1 and no new fall detected, `out_valid` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock of the core side |
| rst_n | input | 1 | Asynchronous active-low reset |
| ce | input | 1 | Slot window; its falling edge freezes the word and control fields |
| dir_sel | input | 1 | 1 selects the transmit port, 0 the receive port |
| pcm_sclk | input | 1 | Transmit-port bit clock (falling edge samples) |
| pcm_sdi | input | 1 | Transmit-port serial data, MSB first |
| code_sclk | input | 1 | Receive-port bit clock (falling edge samples) |
| code_sdi | input | 1 | Receive-port serial data, MSB first |
| rate_sel | input | 2 | Rate code: 00 4-bit, 01 3-bit, 10 2-bit, 11 5-bit |
| law_sel | input | 1 | Coding-law bit for the slot |
| chan_en | input | 1 | Channel-enable bit for the slot |
| chan_init | input | 1 | Channel-init bit for the slot |
| out_ready | input | 1 | Core accepts the presented word this cycle |
| out_valid | output | 1 | A captured word is presented |
| out_word | output | 8 | Captured word, aligned per R3 to R5 |
| out_dir | output | 1 | Direction of the captured slot |
| out_rate | output | 2 | Rate code of the captured slot |
| out_law | output | 1 | Coding-law bit of the captured slot |
| out_en | output | 1 | Channel-enable bit of the captured slot |
| out_init | output | 1 | Channel-init bit of the captured slot |

## Verification
Taking a waiting word and loading a newly synchronized slot can fall in the same system cycle. The bench drives `ce` low on a falling `clk` edge, which makes the detection cycle exact. It holds `out_ready` low so that one word is waiting. It then raises `out_ready` just before the third rising edge after the fall. The scoreboard must see the old word taken first, then the new word presented with `out_valid` still high, and then `out_valid` low one cycle later. A variant that keeps `out_ready` low through the detection cycle checks the other outcome: the new slot is dropped and the old word survives.

// File: rtl/slot_cap_pkg.sv
`timescale 1ns/1ps
package slot_cap_pkg;
  typedef enum logic [1:0] {
    RATE_4B = 2'b00,
    RATE_3B = 2'b01,
    RATE_2B = 2'b10,
    RATE_5B = 2'b11
  } rate_e;

  typedef struct packed {
    logic  dir;
    rate_e rate;
    logic  law;
    logic  en;
    logic  init;
  } slot_ctrl_t;
endpackage

// File: rtl/slot_cap_shreg.sv
`timescale 1ns/1ps
// Serial-in shift register clocked on the falling bit-clock edge, MSB first.
module slot_cap_shreg #(
  parameter int W = 8
) (
  input  logic         sclk,
  input  logic         rst_n,
  input  logic         gate,
  input  logic         sdi,
  output logic [W-1:0] q
);
  always_ff @(negedge sclk or negedge rst_n) begin
    if (!rst_n)
      q <= '0;
    else if (gate)
      q <= {q[W-2:0], sdi};
  end
endmodule

// File: rtl/slot_cap_align.sv
`timescale 1ns/1ps
// Picks the latched window out of the code register: full width for the
// widest rate code, otherwise one bit less, right-justified and zero-extended.
module slot_cap_align #(
  parameter int CODE_W = 5,
  parameter int OUT_W  = 8
) (
  input  logic [CODE_W-1:0] code,
  input  logic [1:0]        rate,
  output logic [OUT_W-1:0]  word
);
  import slot_cap_pkg::*;
  localparam int NARROW_W = CODE_W - 1;

  always_comb begin
    word = '0;
    if (rate_e'(rate) == RATE_5B)
      word[CODE_W-1:0] = code;
    else
      word[NARROW_W-1:0] = code[NARROW_W-1:0];
  end
endmodule

// File: rtl/slot_cap_fallsync.sv
`timescale 1ns/1ps
// Synchronizes an asynchronous level and flags its falling edge for one cycle.
module slot_cap_fallsync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic async_in,
  output logic fall
);
  logic [STAGES:0] chain;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      chain <= '0;
    else
      chain <= {chain[STAGES-1:0], async_in};
  end

  assign fall = chain[STAGES] & ~chain[STAGES-1];
endmodule

// File: rtl/slot_capture.sv
`timescale 1ns/1ps
module slot_capture #(
  parameter int PCM_W       = 8,
  parameter int CODE_W      = 5,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ce,
  input  logic             dir_sel,
  input  logic             pcm_sclk,
  input  logic             pcm_sdi,
  input  logic             code_sclk,
  input  logic             code_sdi,
  input  logic [1:0]       rate_sel,
  input  logic             law_sel,
  input  logic             chan_en,
  input  logic             chan_init,
  input  logic             out_ready,
  output logic             out_valid,
  output logic [PCM_W-1:0] out_word,
  output logic             out_dir,
  output logic [1:0]       out_rate,
  output logic             out_law,
  output logic             out_en,
  output logic             out_init
);
  import slot_cap_pkg::*;

  logic              pcm_gate, code_gate;
  logic [PCM_W-1:0]  pcm_sr;
  logic [CODE_W-1:0] code_sr;
  logic [PCM_W-1:0]  code_word;
  logic [PCM_W-1:0]  hold_word;
  slot_ctrl_t        ctrl_now, hold_ctrl, out_ctrl;
  logic              ce_fall;

  assign pcm_gate  = ce &  dir_sel;
  assign code_gate = ce & ~dir_sel;

  slot_cap_shreg #(.W(PCM_W)) u_pcm_sr (
    .sclk(pcm_sclk), .rst_n(rst_n), .gate(pcm_gate), .sdi(pcm_sdi), .q(pcm_sr)
  );

  slot_cap_shreg #(.W(CODE_W)) u_code_sr (
    .sclk(code_sclk), .rst_n(rst_n), .gate(code_gate), .sdi(code_sdi), .q(code_sr)
  );

  slot_cap_align #(.CODE_W(CODE_W), .OUT_W(PCM_W)) u_align (
    .code(code_sr), .rate(rate_sel), .word(code_word)
  );

  always_comb begin
    ctrl_now.dir  = dir_sel;
    ctrl_now.rate = rate_e'(rate_sel);
    ctrl_now.law  = law_sel;
    ctrl_now.en   = chan_en;
    ctrl_now.init = chan_init;
  end

  // Freeze word and fields on the window's falling edge (serial side).
  always_ff @(negedge ce or negedge rst_n) begin
    if (!rst_n) begin
      hold_word <= '0;
      hold_ctrl <= '0;
    end else begin
      hold_word <= dir_sel ? pcm_sr : code_word;
      hold_ctrl <= ctrl_now;
    end
  end

  slot_cap_fallsync #(.STAGES(SYNC_STAGES)) u_fall (
    .clk(clk), .rst_n(rst_n), .async_in(ce), .fall(ce_fall)
  );

  // Single-entry output stage; the frozen copy is stable for the whole
  // following window, so it is read safely after synchronization.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_word  <= '0;
      out_ctrl  <= '0;
    end else if (ce_fall && (!out_valid || out_ready)) begin
      out_valid <= 1'b1;
      out_word  <= hold_word;
      out_ctrl  <= hold_ctrl;
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end

  assign out_dir  = out_ctrl.dir;
  assign out_rate = out_ctrl.rate;
  assign out_law  = out_ctrl.law;
  assign out_en   = out_ctrl.en;
  assign out_init = out_ctrl.init;
endmodule

// File: rtl/slot_cap_chk.sv
`timescale 1ns/1ps
module slot_cap_chk #(
  parameter int W = 8
) (
  input logic         clk,
  input logic         rst_n,
  input logic         ce_fall,
  input logic         out_valid,
  input logic         out_ready,
  input logic [W-1:0] out_word,
  input logic         out_dir,
  input logic [1:0]   out_rate,
  input logic         out_law,
  input logic         out_en,
  input logic         out_init
);
  p_rx_top_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_dir |-> out_word[7:5] == 3'b000);

  p_narrow_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_dir && out_rate != 2'b11 |-> out_word[4] == 1'b0);

  p_load_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ce_fall && !out_valid |=> out_valid);

  p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_word) && $stable(out_dir)
      && $stable(out_rate) && $stable(out_law) && $stable(out_en) && $stable(out_init));

  p_swap_r10: assert property (@(posedge clk) disable iff (!rst_n)
    ce_fall && out_valid && out_ready |=> out_valid);

  p_consume_r12: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_ready && !ce_fall |=> !out_valid);
endmodule

bind slot_capture slot_cap_chk #(.W(PCM_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .ce_fall(ce_fall),
  .out_valid(out_valid), .out_ready(out_ready), .out_word(out_word),
  .out_dir(out_dir), .out_rate(out_rate), .out_law(out_law),
  .out_en(out_en), .out_init(out_init)
);

// File: tb/slot_capture_test.sv
`timescale 1ns/1ps
module slot_capture_test;
  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rst_n, ce, dir_sel, pcm_sclk, pcm_sdi, code_sclk, code_sdi;
  logic [1:0] rate_sel;
  logic law_sel, chan_en, chan_init, out_ready;
  logic out_valid, out_dir, out_law, out_en, out_init;
  logic [7:0] out_word;
  logic [1:0] out_rate;

  slot_capture uut (
    .clk(clk), .rst_n(rst_n), .ce(ce), .dir_sel(dir_sel),
    .pcm_sclk(pcm_sclk), .pcm_sdi(pcm_sdi), .code_sclk(code_sclk), .code_sdi(code_sdi),
    .rate_sel(rate_sel), .law_sel(law_sel), .chan_en(chan_en), .chan_init(chan_init),
    .out_ready(out_ready), .out_valid(out_valid), .out_word(out_word), .out_dir(out_dir),
    .out_rate(out_rate), .out_law(out_law), .out_en(out_en), .out_init(out_init)
  );

  typedef struct {
    logic [7:0] w;
    logic       d;
    logic [1:0] r;
    logic       l, e, i;
    string      tag;
  } exp_t;

  exp_t       q[$];
  int         n_run = 0, n_fail = 0;
  logic [7:0] pcm_hist;
  logic [4:0] code_hist;
  logic [7:0] last_word;
  logic [7:0] word_a;

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  // port 0 = transmit (sample) port, 1 = receive (code) port
  task automatic send_bits(input bit port, input int n, input logic [15:0] val, input bit live);
    for (int k = n - 1; k >= 0; k--) begin
      @(negedge clk);
      if (port == 1'b0) pcm_sdi = val[k]; else code_sdi = val[k];
      @(negedge clk);
      if (port == 1'b0) begin
        pcm_sclk = 1'b0;
        if (live) pcm_hist = {pcm_hist[6:0], val[k]};
      end else begin
        code_sclk = 1'b0;
        if (live) code_hist = {code_hist[3:0], val[k]};
      end
      @(negedge clk);
      if (port == 1'b0) pcm_sclk = 1'b1; else code_sclk = 1'b1;
    end
  endtask

  // Returns on the falling clk edge at which ce was driven low.
  task automatic run_slot(input logic d, input logic [1:0] r, input logic l, e, i,
                          input int np, input logic [15:0] pv,
                          input int nc, input logic [15:0] cv,
                          input bit push, input string tag);
    exp_t x;
    send_bits(1'b0, 2, 16'hFFFF, 1'b0);   // strays while window closed (R1)
    send_bits(1'b1, 2, 16'hFFFF, 1'b0);   // strays while window closed (R2)
    @(negedge clk);
    dir_sel = d; rate_sel = r; law_sel = l; chan_en = e; chan_init = i;
    @(negedge clk);
    ce = 1'b1;
    send_bits(1'b0, np, pv, d);
    send_bits(1'b1, nc, cv, !d);
    @(negedge clk);
    ce = 1'b0;
    x.w   = d ? pcm_hist : (r == 2'b11 ? {3'b000, code_hist} : {4'b0000, code_hist[3:0]});
    x.d   = d; x.r = r; x.l = l; x.e = e; x.i = i; x.tag = tag;
    if (push) q.push_back(x);
  endtask

  // Scoreboard monitor: compares each accepted word, 1.5 ns after the falling edge.
  initial begin
    exp_t x;
    forever begin
      @(posedge clk);
      #4;
      if (out_valid && out_ready) begin
        if (q.size() == 0)
          chk(1'b0, "R9", "word with nothing expected", {24'd0, out_word}, 32'd0);
        else begin
          x = q.pop_front();
          chk(out_word == x.w && out_dir == x.d && out_rate == x.r && out_law == x.l
              && out_en == x.e && out_init == x.i, x.tag, "word/fields",
              {18'd0, out_dir, out_rate, out_law, out_en, out_init, out_word},
              {18'd0, x.d, x.r, x.l, x.e, x.i, x.w});
          last_word = out_word;
        end
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    rst_n = 1'b0; ce = 1'b0; dir_sel = 1'b0; pcm_sclk = 1'b1; pcm_sdi = 1'b0;
    code_sclk = 1'b1; code_sdi = 1'b0; rate_sel = 2'b00; law_sel = 1'b0;
    chan_en = 1'b0; chan_init = 1'b0; out_ready = 1'b0;
    pcm_hist = '0; code_hist = '0; last_word = '0;
    repeat (4) @(negedge clk);
    #1;
    chk(out_valid == 1'b0, "R11", "valid in reset", {31'd0, out_valid}, 32'd0);
    chk(out_word == 8'h00, "R11", "word in reset", {24'd0, out_word}, 32'd0);
    rst_n = 1'b1;
    out_ready = 1'b1;

    // R3 / R6: plain transmit word, strays on the code port
    run_slot(1'b1, 2'b00, 1'b1, 1'b1, 1'b0, 8, 16'h00A5, 3, 16'h0007, 1'b1, "R3");
    // R3: extra bit clocks push older bits out
    run_slot(1'b1, 2'b10, 1'b0, 1'b1, 1'b0, 12, 16'h03C7, 0, 16'h0, 1'b1, "R3");
    // R4: five-bit code
    run_slot(1'b0, 2'b11, 1'b0, 1'b1, 1'b0, 4, 16'hFFFF, 5, 16'h0016, 1'b1, "R4");
    // R5: four-bit window out of six clocks
    run_slot(1'b0, 2'b00, 1'b1, 1'b1, 1'b0, 0, 16'h0, 6, 16'h0039, 1'b1, "R5");
    // R5: three-bit code 101 in bits 3..1
    run_slot(1'b0, 2'b01, 1'b0, 1'b1, 1'b0, 2, 16'hFFFF, 4, 16'h000A, 1'b1, "R5");
    repeat (6) @(negedge clk);
    chk(last_word[3:1] == 3'b101, "R5", "3-bit field", {29'd0, last_word[3:1]}, 32'd5);
    // R5: two-bit code 01 in bits 3..2
    run_slot(1'b0, 2'b10, 1'b1, 1'b0, 1'b0, 0, 16'h0, 4, 16'h0006, 1'b1, "R5");
    repeat (6) @(negedge clk);
    chk(last_word[3:2] == 2'b01, "R5", "2-bit field", {30'd0, last_word[3:2]}, 32'd1);
    // R1: only 4 new transmit bits; prior stray clocks must not have entered
    run_slot(1'b1, 2'b00, 1'b0, 1'b1, 1'b0, 4, 16'h0003, 5, 16'h001F, 1'b1, "R1");
    // R2: only 2 new code bits; transmit-slot strays must not have entered
    run_slot(1'b0, 2'b11, 1'b0, 1'b1, 1'b0, 3, 16'h0007, 2, 16'h0001, 1'b1, "R2");
    // R6: other control-field values
    run_slot(1'b1, 2'b11, 1'b0, 1'b0, 1'b1, 8, 16'h005A, 0, 16'h0, 1'b1, "R6");

    // R7: latency of the synchronized fall
    run_slot(1'b0, 2'b00, 1'b1, 1'b1, 1'b1, 0, 16'h0, 4, 16'h000C, 1'b1, "R7");
    @(negedge clk);
    @(negedge clk);
    #1;
    chk(out_valid == 1'b0, "R7", "valid after 2nd edge", {31'd0, out_valid}, 32'd0);
    @(negedge clk);
    #1;
    chk(out_valid == 1'b1, "R7", "valid after 3rd edge", {31'd0, out_valid}, 32'd1);
    repeat (4) @(negedge clk);

    // R8 / R9: hold under back-pressure, second slot dropped
    out_ready = 1'b0;
    run_slot(1'b1, 2'b00, 1'b1, 1'b0, 1'b0, 8, 16'h0081, 0, 16'h0, 1'b1, "R8");
    word_a = q[q.size()-1].w;
    repeat (10) @(negedge clk);
    #1;
    chk(out_valid == 1'b1 && out_word == word_a, "R8", "held word",
        {23'd0, out_valid, out_word}, {23'd0, 1'b1, word_a});
    run_slot(1'b0, 2'b11, 1'b0, 1'b1, 1'b1, 0, 16'h0, 5, 16'h0011, 1'b0, "R9");
    repeat (8) @(negedge clk);
    #1;
    chk(out_valid == 1'b1 && out_word == word_a && out_dir == 1'b1, "R9", "old word kept",
        {22'd0, out_dir, out_valid, out_word}, {22'd0, 1'b1, 1'b1, word_a});
    @(negedge clk);
    out_ready = 1'b1;
    repeat (3) @(negedge clk);
    #1;
    chk(out_valid == 1'b0, "R12", "valid after take", {31'd0, out_valid}, 32'd0);
    chk(q.size() == 0, "R9", "pending expectations", q.size(), 32'd0);

    // R10: take and load in the same cycle
    out_ready = 1'b0;
    run_slot(1'b1, 2'b01, 1'b0, 1'b1, 1'b0, 8, 16'h00E4, 0, 16'h0, 1'b1, "R10");
    run_slot(1'b0, 2'b00, 1'b1, 1'b1, 1'b0, 0, 16'h0, 4, 16'h0005, 1'b1, "R10");
    word_a = q[q.size()-1].w;
    @(negedge clk);
    @(negedge clk);
    out_ready = 1'b1;
    @(negedge clk);
    #1;
    chk(out_valid == 1'b1 && out_word == word_a, "R10", "new word after swap",
        {23'd0, out_valid, out_word}, {23'd0, 1'b1, word_a});
    @(negedge clk);
    #1;
    chk(out_valid == 1'b0, "R12", "valid after final take", {31'd0, out_valid}, 32'd0);

    // R11: asynchronous reset mid-run clears the transmit register
    repeat (3) @(negedge clk);
    rst_n = 1'b0;
    #1;
    chk(out_valid == 1'b0 && out_word == 8'h00, "R11", "async clear",
        {23'd0, out_valid, out_word}, 32'd0);
    pcm_hist = '0;
    code_hist = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    run_slot(1'b1, 2'b00, 1'b0, 1'b1, 1'b0, 4, 16'h000A, 0, 16'h0, 1'b1, "R11");

    repeat (10) @(negedge clk);
    chk(q.size() == 0, "R3", "all words delivered", q.size(), 32'd0);
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule